// File: doc/BRIEF.md
# Step Attenuator Control Source Selector

This block decides where the 7-bit attenuation code of a digital step attenuator comes from. A mode pin picks between two sources. One is a 16-bit serial shift register that carries its own device address. The other is a set of seven parallel data pins. The parallel path works in one of two ways, set by the latch-enable line. In latched operation, a high-then-low pulse on latch-enable captures the pins. In transparent operation, latch-enable is held high and the code tracks the pins.

After reset the code sits at maximum attenuation (127). The serial and latched paths hold that value until a word is captured. The transparent path also holds it until a power-up delay has elapsed. The delay is a cycle counter sized from the system clock frequency and a delay in microseconds, and the default is 400 µs.

Once after each reset, the mode pin may only change after a defined preparation sequence: the parallel pins must be zero, and a serial write must clear the serial high bit. A sticky error flag reports any mode change or pin activity that breaks this rule before the sequence is done. After the sequence completes, the mode may change at will.

Top module: `atten_src_ctrl`

## Requirements
- R1: While reset is held and just after it, `attn` is 127, and `dly_done`, `seq_done` and `seq_err` are 0.
- R2: With `ps_sel` low (0 = parallel) and `le` low, changes on `di` leave `attn` unchanged. A cycle with `le` high followed by a cycle with `le` low loads `di` into `attn`, one clock after the low cycle.
- R3: With `ps_sel` low, `le` high and `dly_done` high, `attn` equals the `di` value from the previous clock.
- R4: `dly_done` rises at the clock edge that is the CLK_HZ/1e6 × DELAY_US-th edge after reset release, and stays high. Before that edge the transparent mode leaves `attn` at 127, and the first tracked value appears one edge after `dly_done` rises.
- R5: `sshift` high on a clock shifts `sdata` into the serial register, LSB first. Of the 16 bits shifted, bits 0 to 6 are the attenuation code, bit 7 is the high bit, bits 8 to 10 are the address, and bits 11 to 15 are ignored. Shifting alone never changes `attn`.
- R6: With `ps_sel` high (1 = serial), an `le` high-then-low pulse loads serial bits 6:0 into `attn` only when serial bits 10:8 equal `addr`. Otherwise `attn` keeps its value.
- R7: The path used by a capture is the one `ps_sel` selects in the cycle where `le` falls. When the mode changes to parallel in that same cycle, `di` is captured and the serial word is not.
- R8: `seq_done` sets and stays set when, in serial mode, an address-matching serial capture with bit 7 = 0 occurs while `di` is all zero.
- R9: Before `seq_done`, `seq_err` sets if `ps_sel` goes from serial to parallel, or if `di` is non-zero while `ps_sel` is high. Once set, `seq_err` stays set until reset.
- R10: After `seq_done`, no mode change and no `di` pattern sets `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| ps_sel | input | 1 | Source select: 1 serial, 0 parallel |
| le | input | 1 | Latch enable: falling edge captures; held high = transparent parallel |
| di | input | 7 | Parallel attenuation code pins |
| sdata | input | 1 | Serial data bit |
| sshift | input | 1 | Serial shift strobe, one bit per clock |
| addr | input | 3 | Static device address compared with the serial address field |
| attn | output | 7 | Active attenuation code |
| dly_done | output | 1 | Power-up delay elapsed |
| seq_done | output | 1 | One-time mode-switch preparation completed |
| seq_err | output | 1 | Sticky mode-switch sequencing violation |

## Verification
Two events can land in the same cycle: a latch-enable falling edge and a change of the source select. The bench first loads a matching serial word. It then drops `le` and `ps_sel` together while different data sits on `di`, and expects the parallel code in `attn`. A control run, where `ps_sel` stays high, expects the serial code. The bench also provokes the end of the power-up delay while transparent mode is already active with preset data. It checks `attn` on the edge before, the edge at, and the edge after `dly_done` rises.

// File: rtl/atten_pkg.sv
// Package: shared widths and constants for the attenuator source selector.
// Assumes a 7-bit code, a 16-bit serial frame and a 3-bit device address.
package atten_pkg;
    localparam int ATTN_W  = 7;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 3;
    localparam int HI_BIT  = ATTN_W;           // serial bit after the code
    localparam int ADDR_LO = 8;                // first address bit in frame
    localparam logic [ATTN_W-1:0] ATTN_MAX = '1;
endpackage

// File: rtl/atten_pwrup_timer.sv
// Module: counts the power-up delay after reset release and raises a
// sticky done flag. Assumes CLK_HZ is a whole number of MHz, with the
// delay at least one cycle long.
module atten_pwrup_timer #(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned DELAY_US = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned DLY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;
    localparam int CW = $clog2(DLY_CYC + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(DLY_CYC));

    // Advance the counter until the delay limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end

    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    a_r4_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(cnt));
endmodule

// File: rtl/atten_ser_reg.sv
// Module: 16-bit serial-in shift register, filled LSB first. It splits the
// frame into code, high bit and address match. Assumes one bit per
// sshift cycle.
module atten_ser_reg
    import atten_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              sshift,
    input  logic [ADDR_W-1:0] addr,
    output logic [ATTN_W-1:0] code,
    output logic              hi_bit,
    output logic              hit
);
    logic [FRAME_W-1:0] sr;

    // Shift new bits in at the top, so the first bit ends at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      sr <= '0;
        else if (sshift) sr <= {sdata, sr[FRAME_W-1:1]};
    end

    assign code   = sr[ATTN_W-1:0];
    assign hi_bit = sr[HI_BIT];
    assign hit    = (sr[ADDR_LO +: ADDR_W] == addr);

    a_r5_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        sshift |=> (sr[FRAME_W-1] == $past(sdata)));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sshift |=> $stable(sr));
endmodule

// File: rtl/atten_seq_guard.sv
// Module: enforces the one-time mode-switch preparation after reset.
// Sets a sticky done flag on a clean serial write, and a sticky error flag
// on a premature switch or stray parallel data. Assumes a synchronous
// ps_sel input.
module atten_seq_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic ps_sel,
    input  logic di_zero,
    input  logic ser_wr,
    input  logic wr_hi,
    output logic seq_done,
    output logic seq_err
);
    logic ps_q;
    logic to_par;
    logic bad;

    assign to_par = ps_q && !ps_sel;
    assign bad    = !seq_done && (to_par || (ps_sel && !di_zero));

    // Track the previous mode; reset loads the current pin, so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= ps_sel;
        else        ps_q <= ps_sel;
    end

    // Mark the preparation complete on a clean matching serial write.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_done <= 1'b0;
        else if (ps_sel && ser_wr && !wr_hi && di_zero) seq_done <= 1'b1;
    end

    // Record any sequencing violation until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   seq_err <= 1'b0;
        else if (bad) seq_err <= 1'b1;
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done);
    a_r10_no_late_err: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !seq_err) |=> !seq_err);
endmodule

// File: rtl/atten_src_ctrl.sv
// Module (top): picks the attenuation code source (serial or parallel
// latched or parallel transparent) and holds maximum attenuation from
// reset. Assumes all inputs are synchronous to clk.
module atten_src_ctrl
    import atten_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned DELAY_US = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps_sel,
    input  logic              le,
    input  logic [ATTN_W-1:0] di,
    input  logic              sdata,
    input  logic              sshift,
    input  logic [ADDR_W-1:0] addr,
    output logic [ATTN_W-1:0] attn,
    output logic              dly_done,
    output logic              seq_done,
    output logic              seq_err
);
    logic              le_q;
    logic              le_fall;
    logic [ATTN_W-1:0] ser_code;
    logic              ser_hi;
    logic              ser_hit;
    logic              ser_wr;

    atten_pwrup_timer #(.CLK_HZ(CLK_HZ), .DELAY_US(DELAY_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .done(dly_done));

    atten_ser_reg u_ser (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .sshift(sshift),
        .addr(addr), .code(ser_code), .hi_bit(ser_hi), .hit(ser_hit));

    atten_seq_guard u_guard (
        .clk(clk), .rst_n(rst_n), .ps_sel(ps_sel), .di_zero(di == '0),
        .ser_wr(ser_wr), .wr_hi(ser_hi),
        .seq_done(seq_done), .seq_err(seq_err));

    assign le_fall = le_q && !le;
    assign ser_wr  = ps_sel && le_fall && ser_hit;

    // Remember latch-enable for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= 1'b0;
        else        le_q <= le;
    end

    // Update the active code from the source chosen this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          attn <= ATTN_MAX;
        else if (ser_wr)                     attn <= ser_code;
        else if (!ps_sel && le_fall)         attn <= di;
        else if (!ps_sel && le && dly_done)  attn <= di;
    end

    a_r6_no_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_sel && !ser_hit) |=> $stable(attn));
    a_r4_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (!dly_done && !le_fall) |=> $stable(attn));
    a_r2_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !le_fall) |=> $stable(attn));
endmodule

// File: tb/atten_src_ctrl_tb.sv
module atten_src_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int unsigned DELAY_US = 400;
    localparam int DLY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;
    localparam logic [2:0] MY_ADDR = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps_sel = 1'b0;
    logic le = 1'b0;
    logic [6:0] di = '0;
    logic sdata = 1'b0;
    logic sshift = 1'b0;
    logic [2:0] addr = MY_ADDR;
    logic [6:0] attn;
    logic dly_done, seq_done, seq_err;

    int n_tests = 0;
    int n_fail = 0;
    logic [6:0] exp_attn;

    atten_src_ctrl #(.CLK_HZ(CLK_HZ), .DELAY_US(DELAY_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .ps_sel(ps_sel), .le(le), .di(di),
        .sdata(sdata), .sshift(sshift), .addr(addr), .attn(attn),
        .dly_done(dly_done), .seq_done(seq_done), .seq_err(seq_err));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] frame(input logic [2:0] a, input logic hi,
                                          input logic [6:0] c);
        return {5'b10110, a, hi, c};
    endfunction

    // Expected result of a serial capture.
    function automatic logic [6:0] ser_expect(input logic [15:0] w,
                                              input logic [6:0] prev);
        return (w[10:8] == MY_ADDR) ? w[6:0] : prev;
    endfunction

    task automatic do_reset(input logic mode, input logic [6:0] pins,
                            input logic le_v);
        @(negedge clk);
        rst_n = 1'b0; ps_sel = mode; di = pins; le = le_v; sshift = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 attn", attn, 127);
        check("R1 flags", {dly_done, seq_done, seq_err}, 0);
        rst_n = 1'b1;
    endtask

    task automatic shift_frame(input logic [15:0] w);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            sdata = w[i]; sshift = 1'b1;
        end
        @(negedge clk);
        sshift = 1'b0;
    endtask

    task automatic le_pulse();
        @(negedge clk); le = 1'b1;
        @(negedge clk); le = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [6:0] v;
        void'($urandom(32'd4242));

        // Power-up in transparent parallel mode with a preset on the pins
        do_reset(1'b0, 7'h2A, 1'b1);
        repeat (DLY_CYC - 1) @(posedge clk);
        @(negedge clk);
        check("R4 done before limit", dly_done, 0);
        check("R4 attn held max", attn, 127);
        @(negedge clk);
        check("R4 done at limit", dly_done, 1);
        check("R4 attn at done edge", attn, 127);
        @(negedge clk);
        check("R4 preset applied", attn, 7'h2A);

        // R3: transparent tracking with random codes
        for (int k = 0; k < 12; k++) begin
            v = 7'($urandom);
            di = v;
            @(negedge clk);
            check("R3 follow", attn, v);
        end

        // R2: latched parallel mode
        for (int k = 0; k < 8; k++) begin
            le = 1'b0;
            @(negedge clk);
            exp_attn = attn;
            di = 7'($urandom);
            @(negedge clk);
            check("R2 hold while le low", attn, exp_attn);
            v = 7'($urandom);
            di = v;
            le_pulse();
            check("R2 capture", attn, v);
        end

        // Switch to serial with clean pins (allowed before preparation)
        di = '0;
        @(negedge clk);
        ps_sel = 1'b1;
        exp_attn = attn;
        w = frame(3'b010, 1'b0, 7'h11);
        shift_frame(w);
        check("R5 shift no effect", attn, exp_attn);
        le_pulse();
        check("R6 address mismatch", attn, ser_expect(w, exp_attn));
        check("R8 no done on mismatch", seq_done, 0);
        w = frame(MY_ADDR, 1'b0, 7'($urandom));
        shift_frame(w);
        le_pulse();
        check("R6 address match", attn, ser_expect(w, exp_attn));
        check("R8 done set", seq_done, 1);
        check("R9 no error on clean path", seq_err, 0);

        // R10: free switching after the preparation
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ps_sel = ~ps_sel; di = 7'($urandom) | 7'h01;
        end
        @(negedge clk);
        check("R10 no error", seq_err, 0);

        // R7: capture and mode change in the same cycle
        di = '0; ps_sel = 1'b1; le = 1'b0;
        w = frame(MY_ADDR, 1'b0, 7'h33);
        shift_frame(w);
        @(negedge clk); le = 1'b1;
        @(negedge clk); le = 1'b0; ps_sel = 1'b0; di = 7'h4C;
        @(negedge clk);
        check("R7 parallel wins on switch", attn, 7'h4C);
        @(negedge clk); ps_sel = 1'b1; di = '0;
        le_pulse();
        check("R7 serial kept when mode holds", attn, 7'h33);

        // R9: serial power-up, premature switch to parallel
        do_reset(1'b1, 7'h00, 1'b0);
        @(negedge clk);
        check("R9 clean start", seq_err, 0);
        ps_sel = 1'b0;
        @(negedge clk);
        check("R9 premature switch", seq_err, 1);
        ps_sel = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 sticky", seq_err, 1);

        // R9: stray parallel data in serial mode; serial power-up holds max
        do_reset(1'b1, 7'h00, 1'b0);
        @(negedge clk);
        check("R1 serial start max", attn, 127);
        di = 7'h08;
        @(negedge clk);
        check("R9 stray pins", seq_err, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule